// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Detect

This block compares the rising edges of a feedback signal with the rising edges of a divided reference. Both signals are sampled by a local sampling clock. The reference input `fr_in` is divided by `r_div + 1` inside the block. The divided result acts as the comparison reference, and it is also shown on the `fc_mon` output.

Two active-low pump outputs carry the phase error. `pump_up_n` goes low when the reference edge arrives first, and `pump_dn_n` goes low when the feedback edge arrives first. A pump pulse lasts from the first edge until the sampling clock after the second edge. Its width in sampling clocks is therefore the edge offset plus one. When both edges arrive in the same cycle, each pump produces one minimal pulse.

`pump_nand` is the NAND of the two pumps, so it is high while either pump is active. A counter filters this signal into a digital lock flag; it takes the place of an external RC network and comparator.

The lock flag sets after `lock_need` consecutive clean reference periods. It drops as soon as any pump pulse exceeds a tolerance of `TOL` sampling clocks.

Top module: `pfd_lock_detect`

## Requirements
- R1: While reset is held, the outputs are idle: both pumps high, `pump_nand` low, `locked` low, and both monitors low.
- R2: If a reference edge leads a feedback edge by k sampling cycles (k > 0), `pump_up_n` is low for k+1 cycles and `pump_dn_n` is low for exactly 1 cycle.
- R3: If a feedback edge leads a reference edge by k cycles (k > 0), `pump_dn_n` is low for k+1 cycles and `pump_up_n` is low for exactly 1 cycle.
- R4: Edges that arrive in the same sampling cycle give exactly one 1-cycle low pulse on each pump.
- R5: Falling edges of `fr_in` and `fp_in` produce no pump pulse.
- R6: The divided reference `fc_mon` rises once for every `r_div + 1` rising edges of `fr_in`. After reset, the first rise comes on edge `r_div + 1`. When `r_div` is 0, every `fr_in` rise is a reference edge.
- R7: If `r_div` is lowered below the number of `fr_in` edges already counted, the next `fr_in` rise is a reference edge, and the count restarts from there.
- R8: `pump_nand` is high exactly when at least one pump output is low.
- R9: A reference period runs from one reference edge to the next. It is clean if no pump stays low for more than `TOL` (default 1) consecutive cycles within it. `locked` rises right after the reference edge that closes the `lock_need`-th consecutive clean period.
- R10: `locked` falls in the cycle after a pump pulse grows wider than `TOL` cycles. The period that holds that pulse closes dirty at the next reference edge. After that edge, `lock_need` further clean periods are needed before `locked` rises again.
- R11: While `mon_off` is 1, `fc_mon` and `fp_mon` stay low and the pumps keep working. While `mon_off` is 0, the monitors follow the divided reference and the feedback input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fr_in | input | 1 | Reference input, before the divider |
| fp_in | input | 1 | Divided feedback input |
| r_div | input | R_W (6) | Reference divide value, giving a ratio of r_div+1 |
| lock_need | input | CNT_W (8) | Clean periods required to set lock |
| mon_off | input | 1 | Forces both monitor outputs low |
| pump_up_n | output | 1 | Up pump, active low |
| pump_dn_n | output | 1 | Down pump, active low |
| pump_nand | output | 1 | NAND of the two pumps |
| locked | output | 1 | Lock flag, high when locked |
| fc_mon | output | 1 | Divided reference monitor |
| fp_mon | output | 1 | Feedback monitor |

## Verification
An input rising edge reaches the pump registers SYNC_STAGES+1 sampling cycles later, and the same delay applies to both inputs. Because of this, the bench measures pulse widths by counting low samples over a window that outlasts the delay and the longest pulse. It never samples at a single fixed cycle for widths. `locked` changes one cycle after the reference edge that closes a period, or one cycle after a pump passes the tolerance. `fc_mon` rises one cycle after the reference edge. The bench therefore reads `locked` at the end of each stimulus window and counts `fc_mon` rises over several divider periods, sampling on the falling clock edge.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef struct packed {
        logic up;
        logic dn;
    } pump_t;

    localparam pump_t PUMP_IDLE = '{up: 1'b0, dn: 1'b0};

endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              last;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.sync = (s_q.sync << 1) | STAGES'(din);
        s_d.last = s_q.sync[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign level = s_q.sync[STAGES-1];
    assign rise  = level & ~s_q.last;

    // R5: a rise marks a single sampled edge, never a held level
    p_single_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/pfd_ref_div.sv
module pfd_ref_div #(
    parameter int R_W = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fr_level,
    input  logic           fr_rise,
    input  logic [R_W-1:0] r_val,
    output logic           ref_evt,
    output logic           fc_level
);
    typedef struct packed {
        logic [R_W-1:0] cnt;
        logic           fc;
    } div_t;

    div_t       s_d, s_q;
    logic       term;
    logic [R_W:0] half;
    logic [R_W:0] cnt_inc;

    always_comb begin
        s_d     = s_q;
        term    = fr_rise && (s_q.cnt >= r_val);
        half    = ({1'b0, r_val} + 1'b1) >> 1;
        cnt_inc = {1'b0, s_q.cnt} + 1'b1;
        if (fr_rise) begin
            if (term) begin
                s_d.cnt = '0;
                s_d.fc  = 1'b1;
            end else begin
                s_d.cnt = cnt_inc[R_W-1:0];
                if (cnt_inc >= half) s_d.fc = 1'b0;
            end
        end
        if (r_val == '0) s_d.fc = fr_level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ref_evt  = term;
    assign fc_level = s_q.fc;

    // R7: after any counted edge with a steady ratio the count stays in range
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fr_rise) && r_val == $past(r_val)) |-> (s_q.cnt <= r_val));

    // R6: with a nonzero ratio the monitor rises only after a reference edge
    p_fc_from_evt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(s_q.fc) && $past(r_val) != '0) |-> $past(term));

endmodule

// File: rtl/pfd_phase_cmp.sv
module pfd_phase_cmp
    import pfd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ref_evt,
    input  logic fb_evt,
    output logic up_n,
    output logic dn_n
);
    pump_t p_d, p_q;
    logic  both;

    always_comb begin
        both = p_q.up & p_q.dn;
        p_d  = p_q;
        if (both) begin
            p_d.up = ref_evt;
            p_d.dn = fb_evt;
        end else begin
            p_d.up = p_q.up | ref_evt;
            p_d.dn = p_q.dn | fb_evt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= PUMP_IDLE;
        else        p_q <= p_d;
    end

    assign up_n = ~p_q.up;
    assign dn_n = ~p_q.dn;

    // R4: once both edges are in, both pumps release on the next clock
    p_joint_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (p_q.up && p_q.dn && !ref_evt && !fb_evt) |=> (!p_q.up && !p_q.dn));

    // R2: the up pump starts only from a reference edge
    p_up_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(p_q.up) |-> $past(ref_evt));

    // R3: the down pump starts only from a feedback edge
    p_dn_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(p_q.dn) |-> $past(fb_evt));

    // R2: a lone up pump is held until the feedback edge arrives
    p_up_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (p_q.up && !p_q.dn) |=> p_q.up);

endmodule

// File: rtl/pfd_lock_filter.sv
module pfd_lock_filter #(
    parameter int TOL   = 1,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             ref_evt,
    input  logic [CNT_W-1:0] need,
    output logic             lock
);
    localparam int RUN_W   = $clog2(TOL + 2);
    localparam int RUN_MAX = TOL + 1;

    typedef struct packed {
        logic [RUN_W-1:0] run;
        logic             dirty;
        logic [CNT_W-1:0] good;
        logic             lock;
    } filt_t;

    filt_t          s_d, s_q;
    logic           wide;
    logic           dirty_now;
    logic [CNT_W:0] good_inc;

    always_comb begin
        s_d       = s_q;
        wide      = active && (s_q.run >= RUN_W'(TOL));
        dirty_now = s_q.dirty | wide;
        good_inc  = {1'b0, s_q.good} + 1'b1;

        if (!active)                        s_d.run = '0;
        else if (s_q.run < RUN_W'(RUN_MAX)) s_d.run = s_q.run + 1'b1;

        s_d.dirty = ref_evt ? 1'b0 : dirty_now;

        if (ref_evt) begin
            if (dirty_now) begin
                s_d.good = '0;
            end else begin
                if (s_q.good != '1) s_d.good = good_inc[CNT_W-1:0];
                if (good_inc >= {1'b0, need}) s_d.lock = 1'b1;
            end
        end
        if (wide) s_d.lock = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign lock = s_q.lock;

    // R9: lock only ever rises right after a reference edge
    p_lock_on_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.lock) |-> $past(ref_evt));

    // R10: a pulse past tolerance drops lock on the next clock
    p_wide_unlocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wide |=> !s_q.lock);

    // R10: a dirty period closing restarts the clean count
    p_dirty_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_evt && dirty_now) |=> (s_q.good == '0 && !$rose(s_q.lock)));

endmodule

// File: rtl/pfd_lock_detect.sv
module pfd_lock_detect #(
    parameter int R_W         = 6,
    parameter int CNT_W       = 8,
    parameter int TOL         = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fr_in,
    input  logic             fp_in,
    input  logic [R_W-1:0]   r_div,
    input  logic [CNT_W-1:0] lock_need,
    input  logic             mon_off,
    output logic             pump_up_n,
    output logic             pump_dn_n,
    output logic             pump_nand,
    output logic             locked,
    output logic             fc_mon,
    output logic             fp_mon
);
    logic fr_level, fr_rise;
    logic fp_level, fp_rise;
    logic ref_evt, fc_level;

    pfd_edge_sync #(.STAGES(SYNC_STAGES)) i_fr_sync (
        .clk(clk), .rst_n(rst_n), .din(fr_in), .level(fr_level), .rise(fr_rise)
    );

    pfd_edge_sync #(.STAGES(SYNC_STAGES)) i_fp_sync (
        .clk(clk), .rst_n(rst_n), .din(fp_in), .level(fp_level), .rise(fp_rise)
    );

    pfd_ref_div #(.R_W(R_W)) i_ref_div (
        .clk(clk), .rst_n(rst_n), .fr_level(fr_level), .fr_rise(fr_rise),
        .r_val(r_div), .ref_evt(ref_evt), .fc_level(fc_level)
    );

    pfd_phase_cmp i_phase_cmp (
        .clk(clk), .rst_n(rst_n), .ref_evt(ref_evt), .fb_evt(fp_rise),
        .up_n(pump_up_n), .dn_n(pump_dn_n)
    );

    assign pump_nand = ~(pump_up_n & pump_dn_n);

    pfd_lock_filter #(.TOL(TOL), .CNT_W(CNT_W)) i_lock_filter (
        .clk(clk), .rst_n(rst_n), .active(pump_nand), .ref_evt(ref_evt),
        .need(lock_need), .lock(locked)
    );

    assign fc_mon = fc_level & ~mon_off;
    assign fp_mon = fp_level & ~mon_off;

    // R8: while neither pump is active the lock flag cannot rise
    p_idle_no_glitch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pump_up_n && pump_dn_n && !ref_evt) |=> !$rose(locked));

endmodule

// File: tb/test_pfd_lock_detect.sv
module test_pfd_lock_detect;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fr_in = 1'b0;
    logic       fp_in = 1'b0;
    logic [5:0] r_div = '0;
    logic [7:0] lock_need = 8'd4;
    logic       mon_off = 1'b0;
    logic       pump_up_n, pump_dn_n, pump_nand, locked, fc_mon, fp_mon;

    int errors = 0;
    int checks = 0;
    int cnt_u, cnt_d, fc_rises, fc_seen, fp_seen;
    logic fc_prev = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pfd_lock_detect i_pfd_lock_detect (
        .clk(clk), .rst_n(rst_n), .fr_in(fr_in), .fp_in(fp_in), .r_div(r_div),
        .lock_need(lock_need), .mon_off(mon_off), .pump_up_n(pump_up_n),
        .pump_dn_n(pump_dn_n), .pump_nand(pump_nand), .locked(locked),
        .fc_mon(fc_mon), .fp_mon(fp_mon)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_up(input int off);
        return (off > 0) ? off + 1 : 1;
    endfunction

    function automatic int exp_dn(input int off);
        return (off < 0) ? -off + 1 : 1;
    endfunction

    task automatic step();
        @(negedge clk);
        if (!pump_up_n) cnt_u++;
        if (!pump_dn_n) cnt_d++;
        if (pump_nand != (!pump_up_n || !pump_dn_n)) begin
            chk(1'b0, "R8 nand", int'(pump_nand), int'(!pump_up_n || !pump_dn_n));
        end
        if (fc_mon && !fc_prev) fc_rises++;
        fc_prev = fc_mon;
        if (fc_mon) fc_seen++;
        if (fp_mon) fp_seen++;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        fr_in = 1'b0;
        fp_in = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        fc_rises = 0;
    endtask

    task automatic pair(input int off);
        cnt_u = 0;
        cnt_d = 0;
        if (off >= 0) begin
            fr_in = 1'b1;
            repeat (off) step();
            fp_in = 1'b1;
        end else begin
            fp_in = 1'b1;
            repeat (-off) step();
            fr_in = 1'b1;
        end
        repeat (4) step();
        fr_in = 1'b0;
        fp_in = 1'b0;
        repeat (14) step();
    endtask

    task automatic check_pair(input int off, input string req);
        pair(off);
        chk(cnt_u == exp_up(off), req, cnt_u, exp_up(off));
        chk(cnt_d == exp_dn(off), req, cnt_d, exp_dn(off));
    endtask

    task automatic fr_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            fr_in = 1'b1;
            repeat (3) step();
            fr_in = 1'b0;
            repeat (3) step();
        end
        repeat (4) step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int off;
        void'($urandom(32'd20240611));

        // R1: outputs during reset
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(pump_up_n == 1'b1, "R1 up idle", int'(pump_up_n), 1);
        chk(pump_dn_n == 1'b1, "R1 dn idle", int'(pump_dn_n), 1);
        chk(pump_nand == 1'b0, "R1 nand idle", int'(pump_nand), 0);
        chk(locked == 1'b0, "R1 lock idle", int'(locked), 0);
        chk(fc_mon == 1'b0 && fp_mon == 1'b0, "R1 monitors idle",
            int'(fc_mon) + int'(fp_mon), 0);

        r_div = 6'd0;
        do_reset();

        // Directed corners for R2, R3, R4
        check_pair(0, "R4 coincident");
        check_pair(1, "R2 ref leads 1");
        check_pair(-1, "R3 fb leads 1");
        check_pair(6, "R2 ref leads 6");
        check_pair(-5, "R3 fb leads 5");

        // Random offsets
        fc_seen = 0;
        fp_seen = 0;
        for (int i = 0; i < 30; i++) begin
            off = int'($urandom_range(12)) - 6;
            if (off > 0)      check_pair(off, "R2 random");
            else if (off < 0) check_pair(off, "R3 random");
            else              check_pair(off, "R4 random");
        end
        chk(fc_seen > 0, "R11 fc follows when enabled", fc_seen, 1);
        chk(fp_seen > 0, "R11 fp follows when enabled", fp_seen, 1);

        // R5: falling edges alone give no pulse
        fr_in = 1'b1;
        fp_in = 1'b1;
        repeat (10) step();
        cnt_u = 0;
        cnt_d = 0;
        fr_in = 1'b0;
        repeat (3) step();
        fp_in = 1'b0;
        repeat (12) step();
        chk(cnt_u == 0, "R5 no up on fall", cnt_u, 0);
        chk(cnt_d == 0, "R5 no dn on fall", cnt_d, 0);

        // R6: divider ratios
        r_div = 6'd3;
        do_reset();
        fr_pulses(12);
        chk(fc_rises == 3, "R6 divide by 4", fc_rises, 3);
        r_div = 6'd0;
        do_reset();
        fr_pulses(5);
        chk(fc_rises == 5, "R6 pass through", fc_rises, 5);
        r_div = 6'd5;
        do_reset();
        fr_pulses(13);
        chk(fc_rises == 2, "R6 divide by 6", fc_rises, 2);

        // R7: ratio lowered below the current count
        r_div = 6'd10;
        do_reset();
        fr_pulses(5);
        chk(fc_rises == 0, "R7 before change", fc_rises, 0);
        r_div = 6'd2;
        fr_pulses(1);
        chk(fc_rises == 1, "R7 immediate edge", fc_rises, 1);
        fr_pulses(3);
        chk(fc_rises == 2, "R7 new ratio", fc_rises, 2);

        // R9 and R10: lock acquisition, loss, reacquisition
        r_div = 6'd0;
        lock_need = 8'd4;
        do_reset();
        for (int i = 0; i < 3; i++) pair(0);
        chk(locked == 1'b0, "R9 not yet locked", int'(locked), 0);
        pair(0);
        chk(locked == 1'b1, "R9 locked after need", int'(locked), 1);
        pair(2);
        chk(locked == 1'b0, "R10 wide pulse unlocks", int'(locked), 0);
        for (int i = 0; i < 4; i++) pair(0);
        chk(locked == 1'b0, "R10 dirty period not counted", int'(locked), 0);
        pair(0);
        chk(locked == 1'b1, "R10 relock", int'(locked), 1);
        pair(-3);
        chk(locked == 1'b0, "R10 fb lead unlocks", int'(locked), 0);

        // R9: single-period lock requirement
        lock_need = 8'd1;
        do_reset();
        pair(0);
        chk(locked == 1'b1, "R9 need one", int'(locked), 1);

        // R11: monitors disabled, pumps still active
        mon_off = 1'b1;
        fc_seen = 0;
        fp_seen = 0;
        check_pair(0, "R11 pumps with monitors off");
        check_pair(3, "R11 pumps with monitors off");
        chk(fc_seen == 0, "R11 fc forced low", fc_seen, 0);
        chk(fp_seen == 0, "R11 fp forced low", fp_seen, 0);
        mon_off = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule